// File: doc/BRIEF.md
# Triggered Up-Counter with Timeout Restart

This block is a 16-bit up-counter for low-rate timing jobs. It counts from zero to an auto-reload value and then starts again at zero. It pulses an update event when the count equals the auto-reload value, and it pulses a compare event when the count equals a compare value. Software starts it with one of two commands. A single-run start stops the counter after its next update event. A continuous-run start makes the counter wrap and keep going. Either command may be given while the counter runs, and it changes the run mode without stopping the count.

One external trigger line can hold off the start. When a trigger polarity is selected, a start command only arms the counter, and the first active edge on the trigger starts it. In normal operation the counter then ignores further edges. In timeout mode, each later edge clears the count and the repetition counter, and counting begins again. The compare event then marks a window with no trigger, so it serves as the timeout indication. A repetition counter counts the update events. Pulling enable low returns the whole block to idle.

Top module: `trig_timer`

## Requirements
- R1: A single-run or continuous-run start given while `enable` is low is ignored: the counter neither arms nor runs.
- R2: With `trig_pol` = 2'b00 (no trigger), a start command sets `running` on the next clock with `count` at 0. After that, `count` rises by one on every clock.
- R3: `update_ev` is high exactly while `running` is high and `count` equals `arr_val`. On the following clock `count` is 0.
- R4: `cmp_ev` is high exactly while `running` is high and `count` equals `cmp_val`.
- R5: In single-run mode, `running` falls and `count` returns to 0 on the clock after the update event.
- R6: In continuous-run mode, the counter wraps to 0 after the update event and `running` stays high.
- R7: A single-run start given while the counter runs in continuous mode switches it to single-run. The counter then stops after its next update event.
- R8: A continuous-run start given while the counter runs in single-run mode switches it to continuous. At the auto-reload value the counter then wraps instead of stopping.
- R9: `trig_pol` selects the active trigger edge: 2'b01 rising, 2'b10 falling, 2'b11 both. An edge is a change of `trig_in` against its value at the previous clock. With a polarity selected, a start command arms the counter, and `running` rises on the clock that samples the first active edge.
- R10: With `timeout_en` low, active trigger edges that arrive while the counter runs have no effect on `count` or `rep_count`.
- R11: With `timeout_en` high, an active edge while running clears `count` and `rep_count` to 0 on the next clock, and counting continues. The compare event then signals that no trigger arrived within `cmp_val` clocks.
- R12: `rep_count` rises by one on each update event that is not cleared by a trigger. It wraps modulo 2^REP_W (REP_W = 4 by default).
- R13: While `enable` is low, the next clock clears `count`, `rep_count`, `running` and any pending arm, and sets the mode to single-run.
- R14: If both start commands arrive in the same cycle, the continuous-run start takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low holds the block idle |
| start_single | input | 1 | Single-run start command, one-cycle pulse |
| start_cont | input | 1 | Continuous-run start command, one-cycle pulse |
| timeout_en | input | 1 | Later trigger edges restart the count |
| trig_in | input | 1 | External trigger line |
| trig_pol | input | 2 | Trigger edge select: 00 none, 01 rising, 10 falling, 11 both |
| arr_val | input | 16 | Auto-reload value |
| cmp_val | input | 16 | Compare value |
| count | output | 16 | Current count |
| rep_count | output | 4 | Repetition counter (update events since the last clear) |
| running | output | 1 | Counter is running |
| update_ev | output | 1 | Update event pulse |
| cmp_ev | output | 1 | Compare-match event pulse |

## Verification
All state changes on a clock edge. The two event outputs are decoded without a register from the registered count, so they are valid in the cycle in which the count holds the matching value. A start command or an active trigger edge seen at a clock edge shows up as `running` high with `count` at 0 just after that edge. Every later edge adds one to the count. A timeout clear or a disable shows up in the cycle right after the edge that sampled it. The bench drives and samples only at falling clock edges, and it tracks its place in each run as a count of falling edges since the start. That lets every expected count, event and repetition value be written as a fixed number of falling edges after the stimulus.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_CONT   = 1'b1
    } run_mode_e;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } trig_pol_e;

endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import trig_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] pol,
    output logic       edge_hit,
    output logic       pol_none
);

    typedef struct packed {
        logic trig;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.trig = trig_in;
        rise      = trig_in & ~st_q.trig;
        fall      = ~trig_in & st_q.trig;
        pol_none  = 1'b0;
        edge_hit  = 1'b0;
        case (trig_pol_e'(pol))
            POL_RISE: edge_hit = rise;
            POL_FALL: edge_hit = fall;
            POL_BOTH: edge_hit = rise | fall;
            default:  pol_none = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a rising-edge hit requires the line to be high now
    p_rise_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_RISE && edge_hit) |-> trig_in);

    // R9: a falling-edge hit requires the line to be low now
    p_fall_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_FALL && edge_hit) |-> !trig_in);

endmodule

// File: rtl/trig_run_ctrl.sv
module trig_run_ctrl
    import trig_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_single,
    input  logic start_cont,
    input  logic pol_none,
    input  logic edge_hit,
    input  logic wrap,
    output logic running
);

    typedef struct packed {
        run_mode_e mode;
        logic      armed;
        logic      running;
    } ctrl_st_t;

    ctrl_st_t  st_d, st_q;
    logic      start_ok;
    logic      go_now;
    run_mode_e mode_eff;

    always_comb begin
        st_d     = st_q;
        start_ok = enable & (start_single | start_cont);
        go_now   = 1'b0;

        if (enable && start_cont) begin
            mode_eff = MODE_CONT;
        end else if (enable && start_single) begin
            mode_eff = MODE_SINGLE;
        end else begin
            mode_eff = st_q.mode;
        end

        if (!enable) begin
            st_d.mode    = MODE_SINGLE;
            st_d.armed   = 1'b0;
            st_d.running = 1'b0;
        end else if (st_q.running) begin
            st_d.mode  = mode_eff;
            st_d.armed = 1'b0;
            if (wrap && mode_eff == MODE_SINGLE) begin
                st_d.running = 1'b0;
            end
        end else begin
            st_d.mode = mode_eff;
            go_now    = (st_q.armed | start_ok) & (pol_none | edge_hit);
            if (go_now) begin
                st_d.running = 1'b1;
                st_d.armed   = 1'b0;
            end else begin
                st_d.armed   = st_q.armed | start_ok;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_SINGLE, armed: 1'b0, running: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign running = st_q.running;

    // R13 / R1: a low enable leaves nothing armed or running
    p_disable_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!st_q.running && !st_q.armed));

    // R5: single-run stops after the update event
    p_single_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.running && wrap && mode_eff == MODE_SINGLE) |=> !st_q.running);

    // R6: continuous run keeps going after the update event
    p_cont_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.running && wrap && mode_eff == MODE_CONT) |=> st_q.running);

    // R14: simultaneous starts leave the block in continuous mode
    p_cont_prio_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_single && start_cont) |=> st_q.mode == MODE_CONT);

endmodule

// File: rtl/trig_count_core.sv
module trig_count_core #(
    parameter int CNT_W = 16,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             running,
    input  logic             timeout_en,
    input  logic             edge_hit,
    input  logic [CNT_W-1:0] arr_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic [REP_W-1:0] rep,
    output logic             upd,
    output logic             cmp_hit,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [REP_W-1:0] rep;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     tmo_clear;

    always_comb begin
        st_d      = st_q;
        upd       = running & (st_q.cnt == arr_val);
        cmp_hit   = running & (st_q.cnt == cmp_val);
        tmo_clear = running & timeout_en & edge_hit;
        wrap      = upd & ~tmo_clear;

        if (!enable) begin
            st_d.cnt = '0;
            st_d.rep = '0;
        end else if (tmo_clear) begin
            st_d.cnt = '0;
            st_d.rep = '0;
        end else if (running) begin
            if (upd) begin
                st_d.cnt = '0;
                st_d.rep = st_q.rep + REP_ONE;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign rep = st_q.rep;

    // R2: a running count steps by exactly one away from reload and clear
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running && !upd && !tmo_clear) |=> st_q.cnt == $past(st_q.cnt) + CNT_ONE);

    // R3: the count is zero after an update event
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wrap) |=> st_q.cnt == '0);

    // R10: a discarded trigger edge does not disturb counting
    p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running && !timeout_en && edge_hit && !upd)
        |=> st_q.cnt == $past(st_q.cnt) + CNT_ONE);

    // R11: a timeout-mode edge clears count and repetition counter
    p_tmo_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tmo_clear) |=> (st_q.cnt == '0 && st_q.rep == '0));

    // R12: each kept update event advances the repetition counter
    p_rep_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wrap) |=> st_q.rep == $past(st_q.rep) + REP_ONE);

    // R13: disable clears both counters
    p_disable_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.cnt == '0 && st_q.rep == '0));

endmodule

// File: rtl/trig_timer.sv
module trig_timer
    import trig_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_single,
    input  logic             start_cont,
    input  logic             timeout_en,
    input  logic             trig_in,
    input  logic [1:0]       trig_pol,
    input  logic [CNT_W-1:0] arr_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic [REP_W-1:0] rep_count,
    output logic             running,
    output logic             update_ev,
    output logic             cmp_ev
);

    logic edge_hit;
    logic pol_none;
    logic wrap;
    logic run_q;

    trig_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .pol      (trig_pol),
        .edge_hit (edge_hit),
        .pol_none (pol_none)
    );

    trig_run_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .start_single (start_single),
        .start_cont   (start_cont),
        .pol_none     (pol_none),
        .edge_hit     (edge_hit),
        .wrap         (wrap),
        .running      (run_q)
    );

    trig_count_core #(
        .CNT_W (CNT_W),
        .REP_W (REP_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .running    (run_q),
        .timeout_en (timeout_en),
        .edge_hit   (edge_hit),
        .arr_val    (arr_val),
        .cmp_val    (cmp_val),
        .cnt        (count),
        .rep        (rep_count),
        .upd        (update_ev),
        .cmp_hit    (cmp_ev),
        .wrap       (wrap)
    );

    assign running = run_q;

    // R4: the compare event only occurs while running
    p_cmp_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_ev |-> running);

    // R3: the update event only occurs while running
    p_upd_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
        update_ev |-> running);

endmodule

// File: tb/trig_timer_tb_top.sv
module trig_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        start_single = 1'b0;
    logic        start_cont = 1'b0;
    logic        timeout_en = 1'b0;
    logic        trig_in = 1'b0;
    logic [1:0]  trig_pol = 2'b00;
    logic [15:0] arr_val = 16'd5;
    logic [15:0] cmp_val = 16'd2;
    logic [15:0] count;
    logic [3:0]  rep_count;
    logic        running;
    logic        update_ev;
    logic        cmp_ev;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    trig_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .start_single (start_single),
        .start_cont   (start_cont),
        .timeout_en   (timeout_en),
        .trig_in      (trig_in),
        .trig_pol     (trig_pol),
        .arr_val      (arr_val),
        .cmp_val      (cmp_val),
        .count        (count),
        .rep_count    (rep_count),
        .running      (running),
        .update_ev    (update_ev),
        .cmp_ev       (cmp_ev)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Return to idle through the enable input, then re-enable
    task automatic idle_block();
        enable = 1'b0; start_single = 1'b0; start_cont = 1'b0;
        timeout_en = 1'b0; trig_pol = 2'b00; trig_in = 1'b0;
        tick(1);
        enable = 1'b1;
    endtask

    task automatic t_reset();
        chk("R13 reset count", count, 0);
        chk("R13 reset running", running, 0);
        chk("R3 reset update_ev", update_ev, 0);
        chk("R4 reset cmp_ev", cmp_ev, 0);
    endtask

    task automatic t_single_run();
        idle_block();
        arr_val = 16'd5; cmp_val = 16'd2;
        start_single = 1'b1; tick(1); start_single = 1'b0;
        chk("R2 started", running, 1);
        chk("R2 first count", count, 0);
        tick(1);
        chk("R2 step", count, 1);
        tick(1);
        chk("R4 cmp_ev at cmp", cmp_ev, 1);
        tick(1);
        chk("R4 cmp_ev off", cmp_ev, 0);
        chk("R3 no update early", update_ev, 0);
        tick(2);
        chk("R3 count at arr", count, 5);
        chk("R3 update_ev at arr", update_ev, 1);
        tick(1);
        chk("R5 stopped", running, 0);
        chk("R5 count zero", count, 0);
        chk("R12 rep after one update", rep_count, 1);
        tick(3);
        chk("R5 stays stopped", running, 0);
    endtask

    task automatic t_cont_run();
        idle_block();
        arr_val = 16'd3; cmp_val = 16'd1;
        start_cont = 1'b1; tick(1); start_cont = 1'b0;
        tick(3);
        chk("R3 update at arr cont", update_ev, 1);
        tick(1);
        chk("R6 still running", running, 1);
        chk("R6 wrapped", count, 0);
        tick(4);
        chk("R6 second wrap", count, 0);
        chk("R12 rep two", rep_count, 2);
    endtask

    task automatic t_cont_to_single();
        idle_block();
        arr_val = 16'd4; cmp_val = 16'd1;
        start_cont = 1'b1; tick(1); start_cont = 1'b0;
        tick(2);
        start_single = 1'b1; tick(1); start_single = 1'b0;
        chk("R7 still running after switch", running, 1);
        chk("R7 count", count, 3);
        tick(1);
        chk("R7 update", update_ev, 1);
        tick(1);
        chk("R7 stopped at update", running, 0);
    endtask

    task automatic t_single_to_cont();
        idle_block();
        arr_val = 16'd3; cmp_val = 16'd1;
        start_single = 1'b1; tick(1); start_single = 1'b0;
        tick(1);
        start_cont = 1'b1; tick(1); start_cont = 1'b0;
        tick(1);
        chk("R8 update", update_ev, 1);
        tick(1);
        chk("R8 keeps running", running, 1);
        chk("R8 wrapped", count, 0);
    endtask

    task automatic t_start_while_disabled();
        idle_block();
        enable = 1'b0;
        start_single = 1'b1; tick(1);
        start_single = 1'b0; start_cont = 1'b1; tick(1);
        start_cont = 1'b0; enable = 1'b1;
        tick(3);
        chk("R1 start ignored running", running, 0);
        chk("R1 start ignored count", count, 0);
    endtask

    task automatic t_both_starts();
        idle_block();
        arr_val = 16'd2; cmp_val = 16'd1;
        start_single = 1'b1; start_cont = 1'b1; tick(1);
        start_single = 1'b0; start_cont = 1'b0;
        tick(3);
        chk("R14 continuous wins", running, 1);
        chk("R14 wrapped count", count, 0);
    endtask

    task automatic t_trig_rise_discard();
        idle_block();
        arr_val = 16'd4; cmp_val = 16'd2;
        trig_pol = 2'b01;
        start_cont = 1'b1; tick(1); start_cont = 1'b0;
        chk("R9 armed not running", running, 0);
        tick(2);
        chk("R9 waits for edge", running, 0);
        trig_in = 1'b1; tick(1);
        chk("R9 rising starts", running, 1);
        chk("R9 count zero", count, 0);
        tick(5);
        chk("R12 rep one", rep_count, 1);
        tick(1);
        trig_in = 1'b0; tick(1);
        trig_in = 1'b1; tick(1);
        chk("R10 edge discarded count", count, 3);
        chk("R10 edge discarded rep", rep_count, 1);
    endtask

    task automatic t_trig_fall();
        idle_block();
        arr_val = 16'd9; cmp_val = 16'd2;
        trig_in = 1'b1; trig_pol = 2'b10;
        tick(1);
        start_single = 1'b1; tick(1); start_single = 1'b0;
        tick(1);
        chk("R9 rising ignored on falling select", running, 0);
        trig_in = 1'b0; tick(1);
        chk("R9 falling starts", running, 1);
    endtask

    task automatic t_trig_both();
        idle_block();
        arr_val = 16'd9; cmp_val = 16'd2;
        trig_pol = 2'b11;
        start_single = 1'b1; tick(1); start_single = 1'b0;
        trig_in = 1'b1; tick(1);
        chk("R9 both-edge select starts", running, 1);
    endtask

    task automatic t_timeout();
        idle_block();
        arr_val = 16'd4; cmp_val = 16'd2;
        trig_pol = 2'b01; timeout_en = 1'b1;
        start_cont = 1'b1; tick(1); start_cont = 1'b0;
        trig_in = 1'b1; tick(1);
        chk("R11 first edge starts", running, 1);
        tick(6);
        chk("R11 rep before clear", rep_count, 1);
        chk("R11 count before clear", count, 1);
        trig_in = 1'b0; tick(1);
        trig_in = 1'b1; tick(1);
        chk("R11 count cleared", count, 0);
        chk("R11 rep cleared", rep_count, 0);
        chk("R11 still running", running, 1);
        tick(2);
        chk("R11 timeout cmp_ev", cmp_ev, 1);
    endtask

    task automatic t_rep_wrap();
        idle_block();
        arr_val = 16'd0; cmp_val = 16'd7;
        start_cont = 1'b1; tick(1); start_cont = 1'b0;
        chk("R3 update every cycle at arr 0", update_ev, 1);
        tick(15);
        chk("R12 rep fifteen", rep_count, 15);
        tick(1);
        chk("R12 rep wraps", rep_count, 0);
    endtask

    task automatic t_disable_mid_run();
        idle_block();
        arr_val = 16'd3; cmp_val = 16'd1;
        start_cont = 1'b1; tick(1); start_cont = 1'b0;
        tick(6);
        enable = 1'b0; tick(1);
        chk("R13 running cleared", running, 0);
        chk("R13 count cleared", count, 0);
        chk("R13 rep cleared", rep_count, 0);
        enable = 1'b1; tick(3);
        chk("R13 no resume", running, 0);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_single_run();
        t_cont_run();
        t_cont_to_single();
        t_single_to_cont();
        t_start_while_disabled();
        t_both_starts();
        t_trig_rise_discard();
        t_trig_fall();
        t_trig_both();
        t_timeout();
        t_rep_wrap();
        t_disable_mid_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule